// File: doc/BRIEF.md
# Reset and Sleep/Wake Manager

This block decides when the core of a small 8-bit controller is held in reset and when it sleeps. A reset can come from power-up, from a low level on the external reset pin, or from a watchdog time-out while the watchdog is enabled. Any of these starts a hold period. During that period the core reset output stays high, so the program counter returns to address zero, all port pins turn to inputs and the watchdog and its prescaler stay cleared. The hold length is counted in pulses of a slow reference tick. Two parameters give the count: one for normal clock modes and one for the slow-crystal mode, which a mode input selects. An event that arrives while the count is running starts the count again from zero.

A sleep request from the instruction decoder stops the oscillator and the timer clock, and clears the watchdog once while the watchdog keeps running. Four sources end sleep: the reset pin, a watchdog time-out, a port input change and a comparator output change. The last two are gated by their own enables. In sleep, a watchdog time-out only wakes the core. While awake, the same time-out causes a reset. A two-bit code records the source that ended the last sleep.

The block also gives the register file its reset values as constants. A separate power-on reset output marks resets that began at power-up. Registers that only power-up may clear, such as the memory bank select, use that output.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `por_i` is high and until its hold ends, `core_rst`, `por_rst`, `osc_en`, `tcc_en` and `wdt_clr` are 1, and `sleep_st` and `wake_vld` are 0.
- R2: Once the reset sources are quiet, `core_rst` falls on the clock after the N-th `ref_tick` counted during the hold. N is `HOLD_NORM` when `slow_xtal`=0 and `HOLD_LF` when `slow_xtal`=1.
- R3: A low level on `ext_rst_n` raises `core_rst` after the pin synchronizer. `core_rst` stays high for as long as the pin is low, and the hold count starts only after the pin returns high.
- R4: A one-cycle `wdt_timeout` while awake starts a full hold if `wdt_en`=1 and has no effect if `wdt_en`=0.
- R5: A new reset event during a running hold restarts the count, so the full N ticks are needed after the last event.
- R6: `por_rst` is 1 only during a hold that began at power-up and falls together with `core_rst`. Pin and watchdog resets leave it at 0.
- R7: `init_vals` holds 7 byte slots, slot k at bits [8k+7:8k]. Slot 0 is the control register (0x40, interrupt flag at bit 6). Slot 1 is bank-0 register F (0x00). Slots 2 to 4 are bank-1 registers B, C and D (0xFF). Slots 5 and 6 are bank-1 registers E and F (0x00).
- R8: A one-cycle `sleep_req` while awake and out of reset sets `sleep_st`=1 and `osc_en`=`tcc_en`=0 on the next clock. `wdt_clr` is 1 for exactly that first sleep cycle. `sleep_req` during a hold is ignored.
- R9: A port change wakes only if `pin_wake_en`=1, and a comparator change wakes only if `cmp_wake_en`=1. A wake restores `osc_en`=`tcc_en`=1 on the next clock.
- R10: A watchdog time-out with `wdt_en`=1 during sleep wakes the core without raising `core_rst`.
- R11: `wake_src` codes the waking source as pin 00, watchdog 01, port 10, comparator 11, with that priority when several come together. The code and `wake_vld`=1 hold until the next sleep entry, which clears `wake_vld`. A low reset pin in sleep both wakes (code 00) and resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| sleep_req | input | 1 | Sleep request from the instruction decoder |
| port_chg | input | 1 | Port input change detected |
| pin_wake_en | input | 1 | Enable for wake on port change |
| cmp_chg | input | 1 | Comparator output change detected |
| cmp_wake_en | input | 1 | Enable for wake on comparator change |
| ref_tick | input | 1 | Reference tick for hold counting |
| slow_xtal | input | 1 | Selects the slow-crystal hold count |
| core_rst | output | 1 | Stretched core reset |
| por_rst | output | 1 | Reset that began at power-up |
| osc_en | output | 1 | Oscillator enable |
| tcc_en | output | 1 | Timer/counter clock enable |
| wdt_clr | output | 1 | Watchdog and prescaler clear |
| sleep_st | output | 1 | Sleep status |
| wake_src | output | 2 | Code of the last wake source |
| wake_vld | output | 1 | Wake code is valid since the last sleep entry |
| init_vals | output | 56 | Reset values for the register file |

## Verification
The embedded assertions check rules that hold on every cycle. The hold may end only on a counted tick, with no event in the same cycle, and its counter stays within range. The power-on reset never appears without the core reset, and a core reset always has the oscillator running. Sleep is entered only on an accepted request outside reset, and it ends only on an enabled wake source. `wake_vld` is low whenever the block sleeps, and the watchdog clear is present on the first sleep cycle. Three behaviours can only be shown by the bench's scenarios: the exact tick count in both clock modes, the restart after a late event, and the priority and retention of the wake code across later activity. The constant reset values and the ignoring of disabled wake sources are also left to the bench.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

   typedef enum logic [1:0] {
      WK_PIN  = 2'b00,
      WK_WDOG = 2'b01,
      WK_PORT = 2'b10,
      WK_CMP  = 2'b11
   } wake_code_e;

   typedef enum int unsigned {
      SL_CTRL = 0,
      SL_B0F  = 1,
      SL_B1B  = 2,
      SL_B1C  = 3,
      SL_B1D  = 4,
      SL_B1E  = 5,
      SL_B1F  = 6,
      SL_NUM  = 7
   } init_slot_e;

   // slots whose reset value is all ones
   function automatic bit slot_all_ones(int unsigned s);
      return (s == SL_B1B) || (s == SL_B1C) || (s == SL_B1D);
   endfunction

   // fixed priority: pin, watchdog, port, comparator
   function automatic wake_code_e pick_wake(logic pin, logic wdog, logic port, logic cmp);
      if (pin)       return WK_PIN;
      else if (wdog) return WK_WDOG;
      else if (port) return WK_PORT;
      else if (cmp)  return WK_CMP;
      else           return WK_PIN;
   endfunction

endpackage

// File: rtl/rstwake_sync.sv
module rstwake_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic por_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstwake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) chain <= {STAGES{RST_VAL}};
      else       chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstwake_hold.sv
module rstwake_hold #(
   parameter int HOLD_NORM = 576,
   parameter int HOLD_LF   = 16000
) (
   input  logic clk,
   input  logic por_i,
   input  logic restart_i,
   input  logic tick_i,
   input  logic slow_i,
   output logic hold_o,
   output logic por_hold_o
);
   localparam int MAXH = (HOLD_LF > HOLD_NORM) ? HOLD_LF : HOLD_NORM;
   localparam int CW   = $clog2(MAXH + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          last;

   assign lim  = slow_i ? CW'(HOLD_LF) : CW'(HOLD_NORM);
   assign last = (cnt >= lim - 1'b1);

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         hold_o     <= 1'b1;
         por_hold_o <= 1'b1;
         cnt        <= '0;
      end else if (restart_i) begin
         hold_o <= 1'b1;
         cnt    <= '0;
      end else if (hold_o && tick_i) begin
         if (last) begin
            hold_o     <= 1'b0;
            por_hold_o <= 1'b0;
            cnt        <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // hold ends only on a counted tick with no new event
   p_release_on_tick_r2: assert property (@(posedge clk) disable iff (por_i)
      $fell(hold_o) |-> $past(tick_i) && !$past(restart_i));

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (por_i)
      cnt < CW'(MAXH));

   // a restart leaves the count at zero
   p_restart_zero_r5: assert property (@(posedge clk) disable iff (por_i)
      restart_i |=> hold_o && (cnt == '0));
endmodule

// File: rtl/rstwake_sleep.sv
module rstwake_sleep
   import rstwake_pkg::*;
(
   input  logic       clk,
   input  logic       por_i,
   input  logic       in_reset_i,
   input  logic       rst_evt_i,
   input  logic       sleep_req_i,
   input  logic       pin_low_i,
   input  logic       wdog_hit_i,
   input  logic       port_hit_i,
   input  logic       cmp_hit_i,
   output logic       asleep_o,
   output logic       entry_pulse_o,
   output logic [1:0] wake_src_o,
   output logic       wake_vld_o
);
   logic       any_wake;
   wake_code_e code;

   assign any_wake = pin_low_i | wdog_hit_i | port_hit_i | cmp_hit_i;
   assign code     = pick_wake(pin_low_i, wdog_hit_i, port_hit_i, cmp_hit_i);

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         asleep_o      <= 1'b0;
         entry_pulse_o <= 1'b0;
         wake_src_o    <= WK_PIN;
         wake_vld_o    <= 1'b0;
      end else begin
         entry_pulse_o <= 1'b0;
         if (asleep_o) begin
            if (any_wake) begin
               asleep_o   <= 1'b0;
               wake_src_o <= code;
               wake_vld_o <= 1'b1;
            end
         end else if (sleep_req_i && !in_reset_i && !rst_evt_i) begin
            asleep_o      <= 1'b1;
            entry_pulse_o <= 1'b1;
            wake_vld_o    <= 1'b0;
         end
      end
   end

   p_enter_gated_r8: assert property (@(posedge clk) disable iff (por_i)
      $rose(asleep_o) |-> $past(sleep_req_i) && !$past(in_reset_i));

   p_wake_has_cause_r9: assert property (@(posedge clk) disable iff (por_i)
      $fell(asleep_o) |-> $past(any_wake));

   p_vld_low_asleep_r11: assert property (@(posedge clk) disable iff (por_i)
      asleep_o |-> !wake_vld_o);
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
   import rstwake_pkg::*;
#(
   parameter int HOLD_NORM   = 576,
   parameter int HOLD_LF     = 16000,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int INT_BIT     = 6
) (
   input  logic clk,
   input  logic por_i,
   input  logic ext_rst_n,
   input  logic wdt_en,
   input  logic wdt_timeout,
   input  logic sleep_req,
   input  logic port_chg,
   input  logic pin_wake_en,
   input  logic cmp_chg,
   input  logic cmp_wake_en,
   input  logic ref_tick,
   input  logic slow_xtal,
   output logic core_rst,
   output logic por_rst,
   output logic osc_en,
   output logic tcc_en,
   output logic wdt_clr,
   output logic sleep_st,
   output logic [1:0] wake_src,
   output logic wake_vld,
   output logic [SL_NUM*DATA_W-1:0] init_vals
);
   localparam int NSLOT = SL_NUM;

   if (HOLD_NORM < 1 || HOLD_LF < 1) begin : g_bad_hold
      $error("rstwake_ctrl: hold counts must be at least 1");
   end
   if (INT_BIT < 0 || INT_BIT >= DATA_W) begin : g_bad_int
      $error("rstwake_ctrl: INT_BIT outside the data width");
   end

   logic pin_q, pin_low;
   logic wdog_hit, port_hit, cmp_hit;
   logic asleep, entry_pulse, rst_evt;

   rstwake_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (clk),
      .por_i (por_i),
      .d_i   (ext_rst_n),
      .q_o   (pin_q)
   );

   assign pin_low  = ~pin_q;
   assign wdog_hit = wdt_en & wdt_timeout;
   assign port_hit = port_chg & pin_wake_en;
   assign cmp_hit  = cmp_chg & cmp_wake_en;
   // a watchdog time-out resets only when awake; in sleep it wakes
   assign rst_evt  = pin_low | (wdog_hit & ~asleep);

   rstwake_hold #(.HOLD_NORM(HOLD_NORM), .HOLD_LF(HOLD_LF)) u_hold (
      .clk        (clk),
      .por_i      (por_i),
      .restart_i  (rst_evt),
      .tick_i     (ref_tick),
      .slow_i     (slow_xtal),
      .hold_o     (core_rst),
      .por_hold_o (por_rst)
   );

   rstwake_sleep u_sleep (
      .clk           (clk),
      .por_i         (por_i),
      .in_reset_i    (core_rst),
      .rst_evt_i     (rst_evt),
      .sleep_req_i   (sleep_req),
      .pin_low_i     (pin_low),
      .wdog_hit_i    (wdog_hit),
      .port_hit_i    (port_hit),
      .cmp_hit_i     (cmp_hit),
      .asleep_o      (asleep),
      .entry_pulse_o (entry_pulse),
      .wake_src_o    (wake_src),
      .wake_vld_o    (wake_vld)
   );

   assign sleep_st = asleep;
   assign osc_en   = ~asleep;
   assign tcc_en   = ~asleep;
   assign wdt_clr  = core_rst | entry_pulse;

   for (genvar i = 0; i < NSLOT; i++) begin : g_init
      if (i == SL_CTRL) begin : g_ctrl
         assign init_vals[i*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, 1'b1} << INT_BIT;
      end else if (slot_all_ones(i)) begin : g_ones
         assign init_vals[i*DATA_W +: DATA_W] = '1;
      end else begin : g_zero
         assign init_vals[i*DATA_W +: DATA_W] = '0;
      end
   end

   p_por_within_core_r6: assert property (@(posedge clk) disable iff (por_i)
      por_rst |-> core_rst);

   p_osc_on_in_reset_r1: assert property (@(posedge clk) disable iff (por_i)
      core_rst |-> osc_en && !sleep_st);

   p_clear_on_entry_r8: assert property (@(posedge clk) disable iff (por_i)
      $rose(sleep_st) |-> wdt_clr);

   p_wdog_no_reset_asleep_r10: assert property (@(posedge clk) disable iff (por_i)
      (sleep_st && !pin_low) |=> !$rose(core_rst));
endmodule

// File: tb/rstwake_ctrl_test.sv
`timescale 1ns/1ps
module rstwake_ctrl_test;
   localparam int HN = 4;
   localparam int HL = 9;

   logic clk = 1'b0;
   logic por_i = 1'b1, ext_rst_n = 1'b1, wdt_en = 1'b0, wdt_timeout = 1'b0;
   logic sleep_req = 1'b0, port_chg = 1'b0, pin_wake_en = 1'b0;
   logic cmp_chg = 1'b0, cmp_wake_en = 1'b0, ref_tick = 1'b0, slow_xtal = 1'b0;
   logic core_rst, por_rst, osc_en, tcc_en, wdt_clr, sleep_st, wake_vld;
   logic [1:0] wake_src;
   logic [55:0] init_vals;

   int vectors = 0;
   int fails = 0;
   logic tick_en = 1'b0;
   int ph = 0;

   always #2.5 clk = ~clk;

   rstwake_ctrl #(.HOLD_NORM(HN), .HOLD_LF(HL)) uut (
      .clk(clk), .por_i(por_i), .ext_rst_n(ext_rst_n), .wdt_en(wdt_en),
      .wdt_timeout(wdt_timeout), .sleep_req(sleep_req), .port_chg(port_chg),
      .pin_wake_en(pin_wake_en), .cmp_chg(cmp_chg), .cmp_wake_en(cmp_wake_en),
      .ref_tick(ref_tick), .slow_xtal(slow_xtal), .core_rst(core_rst),
      .por_rst(por_rst), .osc_en(osc_en), .tcc_en(tcc_en), .wdt_clr(wdt_clr),
      .sleep_st(sleep_st), .wake_src(wake_src), .wake_vld(wake_vld),
      .init_vals(init_vals)
   );

   // reference tick every third cycle, updated just after the edge
   always @(posedge clk) begin
      ph <= (ph == 2) ? 0 : ph + 1;
      ref_tick <= tick_en && (ph == 2);
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic negs(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int n);
      n = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (!core_rst) break;
         if (ref_tick) n++;
      end
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1; negs(1); sleep_req = 1'b0;
   endtask

   task automatic t_power_on();
      int n;
      negs(3);
      chk("R1 core_rst", core_rst, 1); chk("R1 por_rst", por_rst, 1);
      chk("R1 osc_en", osc_en, 1);     chk("R1 tcc_en", tcc_en, 1);
      chk("R1 wdt_clr", wdt_clr, 1);   chk("R1 sleep_st", sleep_st, 0);
      chk("R1 wake_vld", wake_vld, 0);
      for (int s = 0; s < 7; s++) begin
         logic [7:0] e;
         e = (s == 0) ? 8'h40 : ((s >= 2 && s <= 4) ? 8'hFF : 8'h00);
         chk("R7 init slot", init_vals[s*8 +: 8], e);
      end
      por_i = 1'b0; negs(1);
      pulse_sleep();                       // ignored while held
      chk("R6 por_rst during hold", por_rst, 1);
      tick_en = 1'b1;
      measure(n);
      chk("R2 normal hold ticks", n, HN);
      chk("R6 por_rst falls with core", por_rst, 0);
      chk("R8 sleep_req in reset ignored", sleep_st, 0);
      tick_en = 1'b0; negs(3);
   endtask

   task automatic t_pin_reset(input logic lf);
      int n;
      slow_xtal = lf; ext_rst_n = 1'b0; negs(4);
      chk("R3 pin reset asserted", core_rst, 1);
      chk("R6 pin reset no por_rst", por_rst, 0);
      tick_en = 1'b1; negs(20);
      chk("R3 held while pin low", core_rst, 1);
      tick_en = 1'b0; ext_rst_n = 1'b1; negs(4);
      tick_en = 1'b1;
      measure(n);
      chk(lf ? "R2 slow hold ticks" : "R3 hold after pin", n, lf ? HL : HN);
      tick_en = 1'b0; slow_xtal = 1'b0; negs(3);
   endtask

   task automatic t_wdog_reset();
      int n;
      wdt_en = 1'b0; wdt_timeout = 1'b1; negs(1); wdt_timeout = 1'b0; negs(3);
      chk("R4 disabled watchdog ignored", core_rst, 0);
      wdt_en = 1'b1; wdt_timeout = 1'b1; negs(1); wdt_timeout = 1'b0;
      chk("R4 watchdog reset", core_rst, 1);
      chk("R6 watchdog no por_rst", por_rst, 0);
      tick_en = 1'b1;
      measure(n);
      chk("R4 watchdog hold ticks", n, HN);
      tick_en = 1'b0; wdt_en = 1'b0; negs(3);
   endtask

   task automatic t_restart();
      int n, seen;
      wdt_en = 1'b1; wdt_timeout = 1'b1; negs(1); wdt_timeout = 1'b0;
      tick_en = 1'b1; seen = 0;
      for (int k = 0; k < 50 && seen < 2; k++) begin
         @(negedge clk);
         if (ref_tick) seen++;
      end
      wdt_timeout = 1'b1; negs(1); wdt_timeout = 1'b0;
      measure(n);
      chk("R5 restart full count", n, HN);
      tick_en = 1'b0; wdt_en = 1'b0; negs(3);
   endtask

   task automatic t_sleep_entry();
      pulse_sleep();
      chk("R8 sleep_st", sleep_st, 1); chk("R8 osc_en off", osc_en, 0);
      chk("R8 tcc_en off", tcc_en, 0); chk("R8 wdt_clr pulse", wdt_clr, 1);
      chk("R11 vld cleared on entry", wake_vld, 0);
      negs(1);
      chk("R8 wdt_clr one cycle", wdt_clr, 0);
   endtask

   task automatic t_wake_gating();
      t_sleep_entry();
      pin_wake_en = 1'b0; cmp_wake_en = 1'b0; wdt_en = 1'b0;
      port_chg = 1'b1; cmp_chg = 1'b1; wdt_timeout = 1'b1; negs(1);
      port_chg = 1'b0; cmp_chg = 1'b0; wdt_timeout = 1'b0; negs(3);
      chk("R9 disabled sources ignored", sleep_st, 1);
      chk("R9 osc stays off", osc_en, 0);
      pin_wake_en = 1'b1; port_chg = 1'b1; negs(1); port_chg = 1'b0;
      chk("R9 port wake", sleep_st, 0); chk("R9 osc back on", osc_en, 1);
      chk("R9 tcc back on", tcc_en, 1);
      chk("R11 port code", wake_src, 2'b10); chk("R11 vld set", wake_vld, 1);
      chk("R9 no reset on wake", core_rst, 0);
      pin_wake_en = 1'b0; negs(2);
      t_sleep_entry();
      cmp_wake_en = 1'b1; cmp_chg = 1'b1; negs(1); cmp_chg = 1'b0;
      chk("R9 comparator wake", sleep_st, 0);
      chk("R11 comparator code", wake_src, 2'b11);
      cmp_wake_en = 1'b0; negs(2);
   endtask

   task automatic t_wdog_wake();
      t_sleep_entry();
      wdt_en = 1'b1; wdt_timeout = 1'b1; negs(1); wdt_timeout = 1'b0;
      chk("R10 watchdog wakes", sleep_st, 0);
      chk("R11 watchdog code", wake_src, 2'b01);
      negs(3);
      chk("R10 no reset from sleep", core_rst, 0);
      wdt_en = 1'b0; negs(2);
   endtask

   task automatic t_priority();
      int n;
      t_sleep_entry();
      pin_wake_en = 1'b1; cmp_wake_en = 1'b1;
      port_chg = 1'b1; cmp_chg = 1'b1; negs(1); port_chg = 1'b0; cmp_chg = 1'b0;
      chk("R11 port over comparator", wake_src, 2'b10);
      cmp_chg = 1'b1; negs(1); cmp_chg = 1'b0; negs(2);
      chk("R11 code kept while awake", wake_src, 2'b10);
      chk("R11 vld kept while awake", wake_vld, 1);
      pin_wake_en = 1'b0; cmp_wake_en = 1'b0;
      t_sleep_entry();
      ext_rst_n = 1'b0; negs(4);
      chk("R11 pin wakes", sleep_st, 0);
      chk("R11 pin code", wake_src, 2'b00);
      chk("R3 pin in sleep resets", core_rst, 1);
      ext_rst_n = 1'b1; negs(4);
      tick_en = 1'b1; measure(n); tick_en = 1'b0;
      chk("R2 hold after sleep reset", n, HN);
      negs(2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      t_power_on();
      t_pin_reset(1'b0);
      t_pin_reset(1'b1);
      t_wdog_reset();
      t_restart();
      t_wake_gating();
      t_wdog_wake();
      t_priority();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule